// File: doc/BRIEF.md
# Smart Card Character Receiver

This block takes one asynchronous character at a time from the shared, half-duplex I/O line of a smart card interface. The line is idle high. A low level starts a character: a start bit, eight data bits and one parity bit, each one elementary time unit (ETU) long. Bit timing comes from an oversampling tick input, `os_tick`, which pulses `OVS` times per ETU. The block samples every bit at the middle of its ETU, timed from the start of the start bit. A start bit that is no longer low at its midpoint is dropped as a glitch.

Two independent controls set the line convention. `cfg_sense` sets the meaning of a low level for the data and parity bits. `cfg_order` sets whether the least or the most significant data bit follows the start bit. `cfg_odd` selects even or odd parity. When `cfg_nak_en` is set and parity fails, the block drives the open-drain pull-down `line_pull` to ask for the character again. It does this only while the retry budget `cfg_max_tries` is not used up. Handshake stays off while the initial TS character of the answer-to-reset is read, with sense and order both clear.

The state machine has six states. S_IDLE waits for a low line. S_START times half an ETU and then goes to S_DATA if the line is still low, or back to S_IDLE if it is not. S_DATA takes nine mid-bit samples and then goes to S_CHECK. S_CHECK decides the outcome in a single cycle and goes to S_TAIL. S_TAIL waits one ETU, which covers the rest of the parity bit plus half an ETU. It then goes to S_NAK if a retry was requested, or to S_IDLE otherwise. S_NAK holds the pull-down for 1.5 ETU and then goes to S_IDLE.

Top module: `sc_char_rx`

## Requirements
- R1: With `cfg_sense`=0 and `cfg_order`=0 (direct convention), a line high is data 1 and the first bit after the start bit is data bit 0. A TS byte of 0x3B is delivered on `rx_data` as 0x3B.
- R2: With `cfg_sense`=1, a line low is taken as logic 1 for all eight data bits and for the parity bit.
- R3: With `cfg_order`=1, the first bit after the start bit is data bit 7 and the eighth is data bit 0.
- R4: Sense and order act independently. All four combinations deliver the transmitted byte.
- R5: `cfg_odd`=0 requires an even number of ones over the data and parity bits, and `cfg_odd`=1 requires an odd number. A character that breaks the rule is a parity failure.
- R6: `rx_valid` is a one-cycle pulse that occurs only for a character with correct parity, and `rx_data` then holds that byte. `rx_valid` and `rx_par_err` are never high together.
- R7: With `cfg_nak_en`=1, a parity failure with retries left raises `line_pull` half an ETU after the parity bit ends. The pull lasts more than 1 and less than 2 ETU, then ends, and the receiver goes back to waiting for a start bit. No `rx_par_err` is raised.
- R8: When the failing attempt is attempt number `cfg_max_tries` (a value of 0 counts as 1), `rx_par_err` pulses and `line_pull` stays low.
- R9: With `cfg_nak_en`=0, every parity failure pulses `rx_par_err` and `line_pull` never rises.
- R10: A low pulse shorter than half an ETU while idle produces no `rx_valid`, no `rx_par_err` and no pull. A character sent after it is received correctly.
- R11: The failed-attempt count clears after each good character and after each reported error.
- R12: After reset `rx_valid`, `rx_par_err`, `line_pull` and `rx_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Oversampling tick, OVS pulses per ETU |
| line_in | input | 1 | Synchronized level of the I/O line |
| cfg_sense | input | 1 | 1: line low means logic 1 |
| cfg_order | input | 1 | 1: most significant bit first |
| cfg_odd | input | 1 | 0 even parity, 1 odd parity |
| cfg_nak_en | input | 1 | Enable error pull-down and retry |
| cfg_max_tries | input | TRY_W | Attempts allowed per character (0 counts as 1) |
| rx_data | output | 8 | Last good received byte |
| rx_valid | output | 1 | One-cycle pulse for a good character |
| rx_par_err | output | 1 | One-cycle pulse for a reported parity error |
| line_pull | output | 1 | Open-drain pull-down enable for the I/O line |

## Verification
`rx_valid` and `rx_par_err` appear two clocks after the tick that takes the parity sample at mid-bit: one clock to reach S_CHECK and one for the output register. `line_pull` rises one ETU after that sample and lasts 1.5 ETU. The bench therefore does not check any single cycle. After each character it releases the line and watches for four ETU, counting strobes, the last byte and the pull cycles. Only then does it compare these with the values that its encoder functions expect. That window ends after the pull has finished and before the next start bit is sent.

// File: rtl/sc_rx_pkg.sv
package sc_rx_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_CHECK,
        S_TAIL,
        S_NAK
    } rx_state_t;
endpackage

// File: rtl/sc_bit_map.sv
module sc_bit_map #(
    parameter int DW = 8
) (
    input  logic [DW:0]   raw,     // raw[0] first bit after start, raw[DW] parity
    input  logic          sense,
    input  logic          order,
    output logic [DW-1:0] data,
    output logic          par
);
    logic [DW:0] lvl;

    assign lvl = sense ? ~raw : raw;
    assign par = lvl[DW];

    for (genvar i = 0; i < DW; i++) begin : g_map
        assign data[i] = order ? lvl[DW-1-i] : lvl[i];
    end
endmodule

// File: rtl/sc_par_chk.sv
module sc_par_chk #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] data,
    input  logic          par,
    input  logic          odd,
    output logic          ok
);
    assign ok = ((^data) ^ par) == odd;
endmodule

// File: rtl/sc_char_rx.sv
module sc_char_rx
    import sc_rx_pkg::*;
#(
    parameter int OVS   = 8,
    parameter int TRY_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             os_tick,
    input  logic             line_in,
    input  logic             cfg_sense,
    input  logic             cfg_order,
    input  logic             cfg_odd,
    input  logic             cfg_nak_en,
    input  logic [TRY_W-1:0] cfg_max_tries,
    output logic [7:0]       rx_data,
    output logic             rx_valid,
    output logic             rx_par_err,
    output logic             line_pull
);
    localparam int DW        = 8;
    localparam int NBITS     = DW + 1;
    localparam int HALF      = OVS / 2;
    localparam int NAK_TICKS = OVS + OVS / 2;
    localparam int CNT_W     = $clog2(2 * OVS);
    localparam int IDX_W     = $clog2(NBITS + 1);

    rx_state_t        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [IDX_W-1:0] idx_q;
    logic [NBITS-1:0] raw_q;
    logic [TRY_W-1:0] tries_q;
    logic             nak_q;

    logic [DW-1:0]    dec_data;
    logic             dec_par;
    logic             par_ok;
    logic [TRY_W:0]   eff_max;
    logic             retry;

    sc_bit_map #(.DW(DW)) u_map (
        .raw   (raw_q),
        .sense (cfg_sense),
        .order (cfg_order),
        .data  (dec_data),
        .par   (dec_par)
    );

    sc_par_chk #(.DW(DW)) u_par (
        .data (dec_data),
        .par  (dec_par),
        .odd  (cfg_odd),
        .ok   (par_ok)
    );

    assign eff_max = (cfg_max_tries == '0) ? (TRY_W+1)'(1) : {1'b0, cfg_max_tries};
    assign retry   = cfg_nak_en && (({1'b0, tries_q} + (TRY_W+1)'(1)) < eff_max);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (!line_in) state_d = S_START;
            S_START: if (os_tick && cnt_q == CNT_W'(HALF-1))
                         state_d = line_in ? S_IDLE : S_DATA;
            S_DATA:  if (os_tick && cnt_q == CNT_W'(OVS-1) && idx_q == IDX_W'(NBITS-1))
                         state_d = S_CHECK;
            S_CHECK: state_d = S_TAIL;
            S_TAIL:  if (os_tick && cnt_q == CNT_W'(OVS-1))
                         state_d = nak_q ? S_NAK : S_IDLE;
            S_NAK:   if (os_tick && cnt_q == CNT_W'(NAK_TICKS-1))
                         state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register and timing datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            raw_q   <= '0;
            tries_q <= '0;
            nak_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q)
                cnt_q <= '0;
            else if (os_tick)
                cnt_q <= (state_q == S_DATA && cnt_q == CNT_W'(OVS-1)) ? '0 : cnt_q + 1'b1;
            if (state_q == S_START)
                idx_q <= '0;
            else if (state_q == S_DATA && os_tick && cnt_q == CNT_W'(OVS-1)) begin
                raw_q[idx_q] <= line_in;
                idx_q        <= idx_q + 1'b1;
            end
            if (state_q == S_CHECK) begin
                if (par_ok) begin
                    tries_q <= '0;
                    nak_q   <= 1'b0;
                end else if (retry) begin
                    tries_q <= tries_q + 1'b1;
                    nak_q   <= 1'b1;
                end else begin
                    tries_q <= '0;
                    nak_q   <= 1'b0;
                end
            end
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data    <= '0;
            rx_valid   <= 1'b0;
            rx_par_err <= 1'b0;
            line_pull  <= 1'b0;
        end else begin
            rx_valid   <= (state_q == S_CHECK) && par_ok;
            rx_par_err <= (state_q == S_CHECK) && !par_ok && !retry;
            line_pull  <= (state_d == S_NAK);
            if (state_q == S_CHECK && par_ok)
                rx_data <= dec_data;
        end
    end

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);                                   // R6
    AST_VALID_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_valid && rx_par_err));                                // R6
    AST_PULL_ENDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(line_pull) |-> state_q == S_IDLE);                   // R7
    AST_ERR_NO_PULL: assert property (@(posedge clk) disable iff (!rst_n)
        rx_par_err |-> !line_pull);                                // R8
    AST_TRIES_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, tries_q} < eff_max);                                // R11
endmodule

// File: tb/sc_char_rx_bench.sv
`timescale 1ns/1ps
module sc_char_rx_bench;
    localparam int OVS   = 8;
    localparam int TRY_W = 3;
    localparam int ETU   = OVS * 2;   // os_tick every second clock

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic os_tick = 1'b0;
    logic tx_line = 1'b1;
    logic cfg_sense = 1'b0, cfg_order = 1'b0, cfg_odd = 1'b0, cfg_nak_en = 1'b0;
    logic [TRY_W-1:0] cfg_max_tries = '0;
    logic [7:0] rx_data;
    logic rx_valid, rx_par_err, line_pull;
    logic line_in;

    int checks = 0;
    int fails  = 0;

    logic mon_clr = 1'b0;
    int n_valid, n_err, n_pull;
    logic [7:0] last_data;

    always #2.5 clk = ~clk;
    always @(negedge clk) os_tick <= ~os_tick;

    assign line_in = tx_line & ~line_pull;

    sc_char_rx #(.OVS(OVS), .TRY_W(TRY_W)) u_sc_char_rx (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .line_in(line_in),
        .cfg_sense(cfg_sense), .cfg_order(cfg_order), .cfg_odd(cfg_odd),
        .cfg_nak_en(cfg_nak_en), .cfg_max_tries(cfg_max_tries),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_par_err(rx_par_err),
        .line_pull(line_pull)
    );

    always @(posedge clk) begin
        if (mon_clr) begin
            n_valid = 0; n_err = 0; n_pull = 0; last_data = 8'h00;
        end else begin
            if (rx_valid) begin n_valid++; last_data = rx_data; end
            if (rx_par_err) n_err++;
            if (line_pull) n_pull++;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [8:0] encode(input logic [7:0] d, input logic bad);
        logic [8:0] b;
        for (int i = 0; i < 8; i++) b[i] = cfg_order ? d[7-i] : d[i];
        b[8] = (^d) ^ cfg_odd ^ bad;
        return cfg_sense ? ~b : b;
    endfunction

    task automatic line_etu(input logic v);
        @(negedge clk);
        tx_line = v;
        repeat (ETU - 1) @(negedge clk);
    endtask

    task automatic send_char(input logic [7:0] d, input logic bad);
        logic [8:0] bits;
        bits = encode(d, bad);
        @(negedge clk); mon_clr = 1'b1;
        @(negedge clk); mon_clr = 1'b0;
        line_etu(1'b0);
        for (int i = 0; i < 9; i++) line_etu(bits[i]);
        @(negedge clk); tx_line = 1'b1;
        repeat (4 * ETU) @(negedge clk);
    endtask

    task automatic expect_ok(input string tag, input logic [7:0] d);
        chk(n_valid == 1, {tag, " valid count"}, n_valid, 1);
        chk(last_data == d, {tag, " data"}, last_data, d);
        chk(n_err == 0 && n_pull == 0, {tag, " no err/pull"}, n_err + n_pull, 0);
    endtask

    task automatic expect_nak(input string tag);
        chk(n_valid == 0 && n_err == 0, {tag, " no strobe"}, n_valid + n_err, 0);
        chk(n_pull > ETU && n_pull < 2 * ETU, {tag, " pull length"}, n_pull, 3 * ETU / 2);
    endtask

    task automatic expect_err(input string tag);
        chk(n_err == 1 && n_valid == 0, {tag, " err pulse"}, n_err, 1);
        chk(n_pull == 0, {tag, " no pull"}, n_pull, 0);
    endtask

    initial begin
        #(5.0 * 200000);
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        chk(!rx_valid && !rx_par_err && !line_pull && rx_data == 0, "R12 reset",
            {rx_valid, rx_par_err, line_pull}, 0);

        // R1: TS byte in direct convention, handshake off
        send_char(8'h3B, 1'b0); expect_ok("R1 direct TS", 8'h3B);
        // R2 + R3: inverse convention
        cfg_sense = 1; cfg_order = 1;
        send_char(8'h3F, 1'b0); expect_ok("R2 R3 inverse", 8'h3F);
        // R2 alone, R3 alone (R4 independence)
        cfg_sense = 1; cfg_order = 0;
        send_char(8'hA6, 1'b0); expect_ok("R2 R4 sense only", 8'hA6);
        cfg_sense = 0; cfg_order = 1;
        send_char(8'h1C, 1'b0); expect_ok("R3 R4 order only", 8'h1C);
        // R5: odd parity, good and bad; R9 handshake off
        cfg_order = 0; cfg_odd = 1;
        send_char(8'h55, 1'b0); expect_ok("R5 odd good", 8'h55);
        send_char(8'h55, 1'b1); expect_err("R5 R9 odd bad");
        cfg_odd = 0;
        send_char(8'h00, 1'b1); expect_err("R5 R9 even bad");

        // R7 + R8: retry limit 3
        cfg_nak_en = 1; cfg_max_tries = 3;
        send_char(8'h81, 1'b1); expect_nak("R7 attempt1");
        send_char(8'h81, 1'b1); expect_nak("R7 attempt2");
        send_char(8'h81, 1'b1); expect_err("R8 attempt3");
        // R8: limit 0 counts as 1
        cfg_max_tries = 0;
        send_char(8'h42, 1'b1); expect_err("R8 limit zero");
        // R11: count cleared by good character
        cfg_max_tries = 2;
        send_char(8'h77, 1'b1); expect_nak("R11 first bad");
        send_char(8'h77, 1'b0); expect_ok("R11 retry good", 8'h77);
        send_char(8'h78, 1'b1); expect_nak("R11 bad after clear");
        send_char(8'h78, 1'b0); expect_ok("R11 good", 8'h78);
        cfg_nak_en = 0;

        // R10: glitch shorter than half an ETU
        @(negedge clk); mon_clr = 1'b1;
        @(negedge clk); mon_clr = 1'b0; tx_line = 1'b0;
        repeat (ETU / 4) @(negedge clk);
        tx_line = 1'b1;
        repeat (3 * ETU) @(negedge clk);
        chk(n_valid == 0 && n_err == 0 && n_pull == 0, "R10 glitch ignored",
            n_valid + n_err + n_pull, 0);
        send_char(8'hC3, 1'b0); expect_ok("R10 after glitch", 8'hC3);

        // R4 R6: random conventions and parity
        void'($urandom(32'd1234));
        for (int k = 0; k < 40; k++) begin
            logic [7:0] d;
            logic bad;
            d = 8'($urandom);
            cfg_sense = 1'($urandom);
            cfg_order = 1'($urandom);
            cfg_odd   = 1'($urandom);
            bad       = ($urandom % 4) == 0;
            send_char(d, bad);
            if (bad) expect_err("R6 random bad");
            else     expect_ok("R4 R6 random", d);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule